// File: doc/BRIEF.md
# Battery protection delay timer

This block gives two battery fault detectors, a short-circuit detect and an over-current detect, a programmable persistence time before either one may turn off the discharge switch. A fault must stay asserted for its configured number of delay steps. Only then does the matching trip output rise. The trip stays latched until software clears it. The delays are counted in a slow, always-running low-power clock domain that supplies a one-cycle step tick. Software writes the two delay codes through a small register port clocked by the CPU clock.

Each new code crosses to the slow domain through a toggle handshake. While the handshake is in flight a busy flag is high, and every write to either setting is dropped. In the slow domain a delay counter adopts a newly delivered code only when it is not counting. Short-circuit protection also needs the discharge path to be enabled, and it then waits for an arming interval before it counts.

Top module: `bprot_delay_timer`

## Requirements
- R1: After reset the short-circuit setting reads 0x10 and the over-current setting reads 0x02, busy is 0 and both trips are 0. The delays in force are 16 ticks for short-circuit and 16 ticks (code 2) for over-current.
- R2: A write with wr_addr=0 loads wr_data[6:0] into the short-circuit setting, and bit 7 of that read port is always 0. A write with wr_addr=1 loads wr_data[5:0] into the over-current setting, and bits 7:6 of its read port are always 0.
- R3: An accepted write raises cfg_busy from the next CPU cycle. Busy lasts at least 3 CPU cycles and until the new setting has been taken over in the slow domain (3 slow cycles). Any write, to either address, made while cfg_busy=1 is ignored.
- R4: With the short-circuit code N (1..127) in force, sc_trip rises on the slow edge of the N-th tick seen while the armed fault input is continuously high. Code 0 acts as 1.
- R5: With the over-current code M (1..63) in force, oc_trip rises on the edge of the 8*M-th tick of a continuous fault. Code 0 acts as 1 (8 ticks).
- R6: If a fault input drops before its delay expires, its count clears. A later fault needs the full delay again.
- R7: A trip stays high after its fault drops, until a trip_clr pulse in the CPU domain clears both trips a few slow cycles later.
- R8: Short-circuit counting happens only while dsg_en=1 and after INIT_TICKS ticks (default 1) have been seen since dsg_en rose. With dsg_en=0 a short-circuit fault never trips.
- R9: A setting delivered while its counter is running does not change that count. It takes effect once the fault has dropped.
- R10: Only slow cycles with slow_tick=1 advance a delay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU register clock |
| rst_cpu_n | input | 1 | CPU-domain reset, active low |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 1 | 0 = short-circuit setting, 1 = over-current setting |
| wr_data | input | 8 | Write data |
| trip_clr | input | 1 | One-cycle request to clear both trips |
| sc_cfg_rd | output | 8 | Short-circuit setting readback |
| oc_cfg_rd | output | 8 | Over-current setting readback |
| cfg_busy | output | 1 | Handshake in flight; writes are ignored |
| clk_slow | input | 1 | Slow low-power clock |
| rst_slow_n | input | 1 | Slow-domain reset, active low |
| slow_tick | input | 1 | One-cycle step enable (one delay step) |
| dsg_en | input | 1 | Discharge path enabled |
| sc_fault | input | 1 | Short-circuit detect, slow-clock synchronous |
| oc_fault | input | 1 | Over-current detect, slow-clock synchronous |
| sc_trip | output | 1 | Latched short-circuit trip |
| oc_trip | output | 1 | Latched over-current trip |

## Verification
The bench measures trip timing to the exact slow edge at the extreme codes 0, 1, 0x7F and 0x3F-range values. A counter that is off by one, or one that does not map code 0 to a single step, misses that edge by one cycle. Writes made while busy=1 are checked at the readback ports, so a design that ignored the guard would show the stray value. A fault dropped and then re-raised, and a write delivered mid-count, expose a counter that keeps stale counts or switches target mid-run. A trip checked while dsg_en is low, and one measured after re-enabling, catch missing arming. Gapped ticks catch a counter that counts clock cycles instead of steps.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  // Code 0 behaves as code 1: the shortest delay is one step.
  function automatic int unsigned eff_code(input int unsigned code);
    return (code == 0) ? 1 : code;
  endfunction

  // Total ticks to a trip for a code, with ticks_per_step ticks per step.
  function automatic int unsigned delay_ticks(input int unsigned code,
                                              input int unsigned ticks_per_step);
    return eff_code(code) * ticks_per_step;
  endfunction

endpackage

// File: rtl/bpd_cpu_regs.sv
module bpd_cpu_regs #(
  parameter int unsigned  DW     = 8,
  parameter int unsigned  SC_W   = 7,
  parameter int unsigned  OC_W   = 6,
  parameter logic [SC_W-1:0] SC_RST = 7'h10,
  parameter logic [OC_W-1:0] OC_RST = 6'h02
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [DW-1:0]   wdata,
  input  logic            trip_clr,
  input  logic            ack_tog,
  output logic [SC_W-1:0] sc_cfg,
  output logic [OC_W-1:0] oc_cfg,
  output logic            req_tog,
  output logic            clr_tog,
  output logic            busy
);

  logic [2:0] ack_s;
  logic       wr_ok;
  logic       unused_rsvd;

  assign unused_rsvd = ^wdata;
  assign busy  = req_tog ^ ack_s[2];
  assign wr_ok = wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_cfg  <= SC_RST;
      oc_cfg  <= OC_RST;
      req_tog <= 1'b0;
      clr_tog <= 1'b0;
      ack_s   <= '0;
    end else begin
      ack_s <= {ack_s[1:0], ack_tog};
      if (trip_clr) clr_tog <= ~clr_tog;
      if (wr_ok) begin
        req_tog <= ~req_tog;
        if (wr_addr) oc_cfg <= wdata[OC_W-1:0];
        else         sc_cfg <= wdata[SC_W-1:0];
      end
    end
  end

  assert_busy_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(sc_cfg) && $stable(oc_cfg)));

  assert_busy_min_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy);

endmodule

// File: rtl/bpd_slow_sync.sv
module bpd_slow_sync #(
  parameter int unsigned  SC_W   = 7,
  parameter int unsigned  OC_W   = 6,
  parameter logic [SC_W-1:0] SC_RST = 7'h10,
  parameter logic [OC_W-1:0] OC_RST = 6'h02
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_tog,
  input  logic            clr_tog,
  input  logic [SC_W-1:0] sc_in,
  input  logic [OC_W-1:0] oc_in,
  output logic            ack_tog,
  output logic [SC_W-1:0] sc_new,
  output logic [OC_W-1:0] oc_new,
  output logic            clr_pulse
);

  logic [2:0] req_s;
  logic [2:0] clr_s;
  logic       req_edge;

  assign req_edge  = req_s[1] ^ req_s[2];
  assign clr_pulse = clr_s[1] ^ clr_s[2];
  assign ack_tog   = req_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s  <= '0;
      clr_s  <= '0;
      sc_new <= SC_RST;
      oc_new <= OC_RST;
    end else begin
      req_s <= {req_s[1:0], req_tog};
      clr_s <= {clr_s[1:0], clr_tog};
      // CPU side holds its registers while busy, so they are stable here.
      if (req_edge) begin
        sc_new <= sc_in;
        oc_new <= oc_in;
      end
    end
  end

  assert_ack_follows_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_edge |=> !req_edge);

endmodule

// File: rtl/bpd_delay_chan.sv
module bpd_delay_chan #(
  parameter int unsigned  W        = 7,
  parameter int unsigned  TPS      = 1,
  parameter logic [W-1:0] RST_CODE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         fault,
  input  logic         clr,
  input  logic [W-1:0] new_code,
  output logic         trip
);

  localparam int unsigned CW = W + $clog2(TPS);

  logic [W-1:0]  act;
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          idle;
  logic          load_ok;
  logic          step_hit;

  assign target   = CW'(bpd_pkg::delay_ticks(32'(act), TPS));
  assign idle     = (cnt == '0);
  assign load_ok  = idle && !fault;
  assign step_hit = fault && tick && ((cnt + CW'(1)) == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= RST_CODE;
      cnt  <= '0;
      trip <= 1'b0;
    end else begin
      if (load_ok) act <= new_code;
      if (clr) begin
        trip <= 1'b0;
        cnt  <= '0;
      end else if (!fault || trip) begin
        cnt <= '0;
      end else if (tick) begin
        if (step_hit) begin
          trip <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assert_cnt_below_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < target);

  assert_trip_needs_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && !(fault && tick)) |=> !trip);

  assert_trip_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !clr) |=> trip);

  assert_load_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(act));

  assert_count_only_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !trip) |=> !trip || $past(clr));

endmodule

// File: rtl/bprot_delay_timer.sv
module bprot_delay_timer #(
  parameter int unsigned SC_W       = 7,
  parameter int unsigned OC_W       = 6,
  parameter int unsigned OC_TPS     = 8,
  parameter int unsigned INIT_TICKS = 1,
  parameter logic [SC_W-1:0] SC_RST = 7'h10,
  parameter logic [OC_W-1:0] OC_RST = 6'h02
) (
  input  logic       clk_cpu,
  input  logic       rst_cpu_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       trip_clr,
  output logic [7:0] sc_cfg_rd,
  output logic [7:0] oc_cfg_rd,
  output logic       cfg_busy,
  input  logic       clk_slow,
  input  logic       rst_slow_n,
  input  logic       slow_tick,
  input  logic       dsg_en,
  input  logic       sc_fault,
  input  logic       oc_fault,
  output logic       sc_trip,
  output logic       oc_trip
);

  localparam int unsigned REG_W = 8;
  localparam int unsigned AW    = $clog2(INIT_TICKS + 1);

  logic [SC_W-1:0] sc_cfg, sc_new;
  logic [OC_W-1:0] oc_cfg, oc_new;
  logic            req_tog, ack_tog, clr_tog, clr_pulse;
  logic [AW-1:0]   arm_cnt;
  logic            armed;
  logic            sc_fault_armed;

  assign sc_cfg_rd = {{(REG_W-SC_W){1'b0}}, sc_cfg};
  assign oc_cfg_rd = {{(REG_W-OC_W){1'b0}}, oc_cfg};

  bpd_cpu_regs #(.DW(REG_W), .SC_W(SC_W), .OC_W(OC_W), .SC_RST(SC_RST), .OC_RST(OC_RST)) u_regs (
    .clk(clk_cpu), .rst_n(rst_cpu_n), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wr_data),
    .trip_clr(trip_clr), .ack_tog(ack_tog), .sc_cfg(sc_cfg), .oc_cfg(oc_cfg),
    .req_tog(req_tog), .clr_tog(clr_tog), .busy(cfg_busy)
  );

  bpd_slow_sync #(.SC_W(SC_W), .OC_W(OC_W), .SC_RST(SC_RST), .OC_RST(OC_RST)) u_sync (
    .clk(clk_slow), .rst_n(rst_slow_n), .req_tog(req_tog), .clr_tog(clr_tog),
    .sc_in(sc_cfg), .oc_in(oc_cfg), .ack_tog(ack_tog), .sc_new(sc_new),
    .oc_new(oc_new), .clr_pulse(clr_pulse)
  );

  // Arming interval after the discharge path is enabled.
  always_ff @(posedge clk_slow or negedge rst_slow_n) begin
    if (!rst_slow_n) begin
      arm_cnt <= '0;
      armed   <= 1'b0;
    end else if (!dsg_en) begin
      arm_cnt <= '0;
      armed   <= 1'b0;
    end else if (slow_tick && !armed) begin
      if ((arm_cnt + AW'(1)) == AW'(INIT_TICKS)) armed <= 1'b1;
      else                                       arm_cnt <= arm_cnt + AW'(1);
    end
  end

  assign sc_fault_armed = sc_fault && armed;

  bpd_delay_chan #(.W(SC_W), .TPS(1), .RST_CODE(SC_RST)) u_sc_chan (
    .clk(clk_slow), .rst_n(rst_slow_n), .tick(slow_tick), .fault(sc_fault_armed),
    .clr(clr_pulse), .new_code(sc_new), .trip(sc_trip)
  );

  bpd_delay_chan #(.W(OC_W), .TPS(OC_TPS), .RST_CODE(OC_RST)) u_oc_chan (
    .clk(clk_slow), .rst_n(rst_slow_n), .tick(slow_tick), .fault(oc_fault),
    .clr(clr_pulse), .new_code(oc_new), .trip(oc_trip)
  );

  assert_unarmed_no_trip_R8: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    (!armed && !sc_trip) |=> !sc_trip);

  assert_disarm_on_dsg_low_R8: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
    !dsg_en |=> !armed);

endmodule

// File: tb/bprot_delay_timer_test.sv
module bprot_delay_timer_test;

  logic       clk_cpu = 1'b0, clk_slow = 1'b0;
  logic       rst_cpu_n = 1'b0, rst_slow_n = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0, trip_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       slow_tick = 1'b1, dsg_en = 1'b1, sc_fault = 1'b0, oc_fault = 1'b0;
  logic [7:0] sc_cfg_rd, oc_cfg_rd;
  logic       cfg_busy, sc_trip, oc_trip;

  int checks = 0;
  int fails  = 0;

  always #2  clk_cpu  = ~clk_cpu;
  always #23 clk_slow = ~clk_slow;

  bprot_delay_timer uut (
    .clk_cpu(clk_cpu), .rst_cpu_n(rst_cpu_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trip_clr(trip_clr), .sc_cfg_rd(sc_cfg_rd), .oc_cfg_rd(oc_cfg_rd),
    .cfg_busy(cfg_busy), .clk_slow(clk_slow), .rst_slow_n(rst_slow_n), .slow_tick(slow_tick),
    .dsg_en(dsg_en), .sc_fault(sc_fault), .oc_fault(oc_fault), .sc_trip(sc_trip), .oc_trip(oc_trip)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic a, input logic [7:0] d);
    @(negedge clk_cpu);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_cpu);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    @(negedge clk_cpu);
    while (cfg_busy) @(negedge clk_cpu);
    repeat (3) @(negedge clk_slow);
  endtask

  task automatic clear_trips();
    @(negedge clk_cpu) trip_clr = 1'b1;
    @(negedge clk_cpu) trip_clr = 1'b0;
    repeat (5) @(negedge clk_slow);
  endtask

  // Raise a fault and check that the trip rises exactly on the ticks-th edge.
  task automatic measure(input bit is_oc, input int ticks, input string req,
                         input bit do_wr, input logic [7:0] wdat);
    @(negedge clk_slow);
    if (is_oc) oc_fault = 1'b1; else sc_fault = 1'b1;
    if (do_wr) cpu_write(1'b0, wdat);
    repeat (ticks - 1) @(negedge clk_slow);
    check({req, " before expiry"}, int'(is_oc ? oc_trip : sc_trip), 0);
    @(negedge clk_slow);
    check({req, " at expiry"}, int'(is_oc ? oc_trip : sc_trip), 1);
    sc_fault = 1'b0; oc_fault = 1'b0;
    clear_trips();
  endtask

  task automatic t_reset();
    check("R1 sc reset value", int'(sc_cfg_rd), 'h10);
    check("R1 oc reset value", int'(oc_cfg_rd), 'h02);
    check("R1 busy at reset", int'(cfg_busy), 0);
    check("R1 sc trip at reset", int'(sc_trip), 0);
    check("R1 oc trip at reset", int'(oc_trip), 0);
    measure(1'b0, 16, "R1 default sc delay", 1'b0, 8'h0);
    measure(1'b1, 16, "R1 default oc delay", 1'b0, 8'h0);
  endtask

  task automatic t_regs();
    cpu_write(1'b0, 8'hFF);
    wait_ready();
    check("R2 sc reserved bit", int'(sc_cfg_rd), 'h7F);
    measure(1'b0, 127, "R4 sc max code", 1'b0, 8'h0);
    cpu_write(1'b1, 8'hC3);
    wait_ready();
    check("R2 oc reserved bits", int'(oc_cfg_rd), 'h03);
    measure(1'b1, 24, "R5 oc code 3", 1'b0, 8'h0);
  endtask

  task automatic t_busy();
    cpu_write(1'b0, 8'h05);
    check("R3 busy after write", int'(cfg_busy), 1);
    cpu_write(1'b0, 8'h33);
    cpu_write(1'b1, 8'h11);
    check("R3 sc write ignored", int'(sc_cfg_rd), 'h05);
    check("R3 oc write ignored", int'(oc_cfg_rd), 'h03);
    wait_ready();
    check("R3 busy clears", int'(cfg_busy), 0);
    cpu_write(1'b1, 8'h00);
    wait_ready();
    check("R3 write accepted after busy", int'(oc_cfg_rd), 'h00);
  endtask

  task automatic t_small_codes();
    measure(1'b1, 8, "R5 oc code 0", 1'b0, 8'h0);
    cpu_write(1'b0, 8'h00);
    wait_ready();
    measure(1'b0, 1, "R4 sc code 0", 1'b0, 8'h0);
    cpu_write(1'b0, 8'h01);
    wait_ready();
    measure(1'b0, 1, "R4 sc code 1", 1'b0, 8'h0);
    cpu_write(1'b0, 8'h05);
    wait_ready();
    measure(1'b0, 5, "R4 sc code 5", 1'b0, 8'h0);
  endtask

  task automatic t_drop();
    @(negedge clk_slow) sc_fault = 1'b1;
    repeat (4) @(negedge clk_slow);
    sc_fault = 1'b0;
    @(negedge clk_slow);
    check("R6 no trip on short fault", int'(sc_trip), 0);
    measure(1'b0, 5, "R6 full delay after drop", 1'b0, 8'h0);
  endtask

  task automatic t_sticky();
    @(negedge clk_slow) sc_fault = 1'b1;
    repeat (5) @(negedge clk_slow);
    sc_fault = 1'b0;
    repeat (6) @(negedge clk_slow);
    check("R7 trip held after fault drops", int'(sc_trip), 1);
    clear_trips();
    check("R7 trip cleared", int'(sc_trip), 0);
  endtask

  task automatic t_arm();
    cpu_write(1'b0, 8'h04);
    wait_ready();
    @(negedge clk_slow) dsg_en = 1'b0; sc_fault = 1'b1;
    repeat (10) @(negedge clk_slow);
    check("R8 no trip while disabled", int'(sc_trip), 0);
    dsg_en = 1'b1;
    repeat (4) @(negedge clk_slow);
    check("R8 arming adds one tick", int'(sc_trip), 0);
    @(negedge clk_slow);
    check("R8 trip after arming", int'(sc_trip), 1);
    sc_fault = 1'b0;
    clear_trips();
  endtask

  task automatic t_idle_load();
    cpu_write(1'b0, 8'h0A);
    wait_ready();
    measure(1'b0, 10, "R9 old code holds mid-count", 1'b1, 8'h14);
    measure(1'b0, 20, "R9 new code after idle", 1'b0, 8'h0);
  endtask

  task automatic t_gapped();
    cpu_write(1'b0, 8'h03);
    wait_ready();
    @(negedge clk_slow) sc_fault = 1'b1; slow_tick = 1'b1;
    for (int i = 1; i < 5; i++) begin
      @(negedge clk_slow);
      check("R10 gapped ticks before expiry", int'(sc_trip), 0);
      slow_tick = (i % 2 == 0);
    end
    @(negedge clk_slow);
    check("R10 trip on third tick", int'(sc_trip), 1);
    slow_tick = 1'b1; sc_fault = 1'b0;
    clear_trips();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_slow);
    rst_cpu_n = 1'b1; rst_slow_n = 1'b1;
    repeat (3) @(negedge clk_slow);
    @(negedge clk_cpu);
    t_reset();
    t_regs();
    t_busy();
    t_small_codes();
    t_drop();
    t_sticky();
    t_arm();
    t_idle_load();
    t_gapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule